// File: doc/BRIEF.md
# Segmented Logical-to-Linear Address Translator

This block converts a logical address, a 16-bit segment value paired with an offset, into a linear address. It has two modes, chosen per request. In real mode the segment is scaled by sixteen and added to a 16-bit offset, giving a 20-bit address that wraps at 1 MB. In protected mode the segment value is read as a selector. The selector picks an entry in one of two on-chip descriptor tables. The entry's base is added to a 32-bit offset, and the offset is checked against the entry's limit, which may count bytes or 4 KB units.

Software or a sequencer fills the two descriptor tables through a simple write port. Each request gives a registered result one cycle later: a linear address, a valid flag and a fault flag. Paging and privilege checking are not part of this unit.

Top module: `seg_xlate`

## Requirements
- R1: With req_prot=0, out_lin = (req_seg*16 + req_ofs[15:0]) mod 2^20, zero-extended to 32 bits. req_ofs[31:16] is ignored and out_fault is 0.
- R2: In real mode, segment A1F0h with offset 04C0h gives A23C0h. Segment FFFFh with offset 0010h wraps to 00000h because the carry out of bit 19 is dropped.
- R3: With req_prot=1, the table index is req_seg[15:3]. Bit req_seg[2] selects the table: 0 is the global table and 1 is the local table. Bits req_seg[1:0] have no effect.
- R4: For an accepted protected request, out_lin = (base + req_ofs) mod 2^32.
- R5: When a descriptor's granularity bit is 0, the limit counts bytes. An offset equal to the limit passes, and an offset greater than the limit sets out_fault.
- R6: When the granularity bit is 1, the effective limit is {limit, 12'hFFF}. An offset above it sets out_fault.
- R7: A protected request whose index is DEPTH or larger (default DEPTH 16) sets out_fault.
- R8: When out_fault is 1, out_lin is 0.
- R9: out_valid is high in exactly the cycle after each cycle with req_valid high. Without a request, out_valid and out_fault are 0 and out_lin holds its previous value.
- R10: A pulse on wr_en stores {wr_base, wr_limit, wr_gran} at wr_idx in the table chosen by wr_local (0 global, 1 local). The stored entry is seen by requests from the next cycle on. A request in the same cycle as the write sees the old contents. A write with wr_idx of DEPTH or larger changes nothing.
- R11: After reset, out_valid, out_fault and out_lin are 0 and every descriptor is zero (base 0, limit 0, byte granularity). Offset 0 then passes with linear address 0, and offset 1 faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request |
| req_prot | input | 1 | 1 = protected mode, 0 = real mode |
| req_seg | input | 16 | Segment value or selector |
| req_ofs | input | 32 | Offset (real mode uses bits 15:0) |
| wr_en | input | 1 | Descriptor write strobe |
| wr_local | input | 1 | Target table: 0 global, 1 local |
| wr_idx | input | 13 | Descriptor index to write |
| wr_base | input | 32 | Descriptor base |
| wr_limit | input | 20 | Descriptor limit |
| wr_gran | input | 1 | Limit unit: 0 bytes, 1 4 KB |
| out_valid | output | 1 | Result valid, one cycle after request |
| out_lin | output | 32 | Linear address |
| out_fault | output | 1 | Limit or index fault |

## Verification
Real-mode patterns cover a plain sum, the 1 MB wraparound and an offset with junk in its upper half. Together they separate a correct 20-bit adder from a 32-bit one or from one that uses the whole offset. Protected patterns use the same index in both tables and a selector with its low two bits set, which exposes a wrong table-select bit or a wrong index field. Each limit is probed at exactly the limit and one past it, in both byte and page units, so off-by-one and unscaled-limit errors show up. Out-of-range indices, a write to an index past the table depth, a write and a request in the same cycle, and an idle cycle after a result check the edges of table access and of the output register.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int SEG_W   = 16;
  localparam int OFS_W   = 32;
  localparam int LIN_W   = 32;
  localparam int RLIN_W  = 20;
  localparam int LIM_W   = 20;
  localparam int PAGE_SH = 12;
  localparam int SEL_IDX_W = 13;
  localparam int SEL_TI_BIT = 2;
  localparam int SEL_IDX_LSB = 3;

  typedef struct packed {
    logic [LIN_W-1:0] base;
    logic [LIM_W-1:0] limit;
    logic             gran;
  } desc_t;
endpackage

// File: rtl/seg_desc_store.sv
module seg_desc_store
  import seg_xlate_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int IDX_W = SEL_IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  desc_t            wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output desc_t            rd_data,
  output logic             rd_hit
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  desc_t ent_q [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    desc_t q, d;
    logic  hit_w;
    always_comb begin
      hit_w = wr_en && (wr_idx == IDX_W'(e));
      d     = hit_w ? wr_data : q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end
    assign ent_q[e] = q;
  end

  always_comb begin
    rd_hit  = (rd_idx < IDX_W'(DEPTH));
    rd_data = rd_hit ? ent_q[rd_idx[AW-1:0]] : '0;
  end

  // R10: an in-range write is present in the entry on the next cycle
  a_r10_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_idx < IDX_W'(DEPTH))) |=>
      (ent_q[$past(wr_idx[AW-1:0])] == $past(wr_data)));
endmodule

// File: rtl/seg_real_calc.sv
module seg_real_calc
  import seg_xlate_pkg::*;
(
  input  logic [SEG_W-1:0]  seg,
  input  logic [15:0]       ofs,
  output logic [RLIN_W-1:0] lin
);
  logic [RLIN_W-1:0] seg_sh;
  always_comb begin
    seg_sh = {seg, 4'h0};
    lin    = seg_sh + {4'h0, ofs};
  end
endmodule

// File: rtl/seg_prot_calc.sv
module seg_prot_calc
  import seg_xlate_pkg::*;
(
  input  desc_t            desc,
  input  logic             hit,
  input  logic [OFS_W-1:0] ofs,
  output logic [LIN_W-1:0] lin,
  output logic             fault
);
  logic [OFS_W-1:0] eff_lim;
  always_comb begin
    if (desc.gran) eff_lim = {desc.limit, {PAGE_SH{1'b1}}};
    else           eff_lim = {{(OFS_W-LIM_W){1'b0}}, desc.limit};
    fault = !hit || (ofs > eff_lim);
    lin   = desc.base + ofs;
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_prot,
  input  logic [15:0]          req_seg,
  input  logic [31:0]          req_ofs,
  input  logic                 wr_en,
  input  logic                 wr_local,
  input  logic [12:0]          wr_idx,
  input  logic [31:0]          wr_base,
  input  logic [19:0]          wr_limit,
  input  logic                 wr_gran,
  output logic                 out_valid,
  output logic [31:0]          out_lin,
  output logic                 out_fault
);
  localparam int NTBL = 2;

  logic [SEL_IDX_W-1:0] sel_idx;
  logic                 sel_tbl;
  desc_t                wr_data;
  desc_t                tbl_data [NTBL];
  logic                 tbl_hit  [NTBL];

  assign sel_idx = req_seg[SEG_W-1:SEL_IDX_LSB];
  assign sel_tbl = req_seg[SEL_TI_BIT];
  assign wr_data = '{base: wr_base, limit: wr_limit, gran: wr_gran};

  for (genvar t = 0; t < NTBL; t++) begin : g_tbl
    logic tbl_wr;
    assign tbl_wr = wr_en && (wr_local == t[0]);
    seg_desc_store #(.DEPTH(DEPTH), .IDX_W(SEL_IDX_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (tbl_wr),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .rd_idx  (sel_idx),
      .rd_data (tbl_data[t]),
      .rd_hit  (tbl_hit[t])
    );
  end

  logic [RLIN_W-1:0] real_lin;
  seg_real_calc u_real (
    .seg (req_seg),
    .ofs (req_ofs[15:0]),
    .lin (real_lin)
  );

  logic [LIN_W-1:0] prot_lin;
  logic             prot_fault;
  seg_prot_calc u_prot (
    .desc  (tbl_data[sel_tbl]),
    .hit   (tbl_hit[sel_tbl]),
    .ofs   (req_ofs),
    .lin   (prot_lin),
    .fault (prot_fault)
  );

  logic [LIN_W-1:0] mode_lin;
  logic             mode_fault;
  logic             nxt_valid, nxt_fault;
  logic [LIN_W-1:0] nxt_lin;
  logic             valid_q, fault_q;
  logic [LIN_W-1:0] lin_q;

  always_comb begin
    if (req_prot) begin
      mode_lin   = prot_lin;
      mode_fault = prot_fault;
    end else begin
      mode_lin   = {{(LIN_W-RLIN_W){1'b0}}, real_lin};
      mode_fault = 1'b0;
    end
    nxt_valid = req_valid;
    nxt_fault = req_valid && mode_fault;
    if (req_valid) nxt_lin = mode_fault ? '0 : mode_lin;
    else           nxt_lin = lin_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      fault_q <= 1'b0;
      lin_q   <= '0;
    end else begin
      valid_q <= nxt_valid;
      fault_q <= nxt_fault;
      lin_q   <= nxt_lin;
    end
  end

  assign out_valid = valid_q;
  assign out_fault = fault_q;
  assign out_lin   = lin_q;

  // R9: one-cycle latency, no spurious valid
  a_r9_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);
  a_r9_no_req_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!out_valid && !out_fault && $stable(out_lin)));
  // R1: real mode never faults and stays below 1 MB
  a_r1_real_range: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_prot) |=> (!out_fault && (out_lin[31:20] == '0)));
  // R7: index beyond table depth faults
  a_r7_index_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_prot && (req_seg[15:3] >= 13'(DEPTH))) |=> out_fault);
  // R8: faulting result carries a zero address
  a_r8_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_fault |-> (out_valid && (out_lin == '0)));
endmodule

// File: tb/seg_xlate_bench.sv
`timescale 1ns/1ps
module seg_xlate_bench;
  logic        clk, rst_n;
  logic        req_valid, req_prot;
  logic [15:0] req_seg;
  logic [31:0] req_ofs;
  logic        wr_en, wr_local, wr_gran;
  logic [12:0] wr_idx;
  logic [31:0] wr_base;
  logic [19:0] wr_limit;
  logic        out_valid, out_fault;
  logic [31:0] out_lin;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  seg_xlate u_seg_xlate (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_prot(req_prot),
    .req_seg(req_seg), .req_ofs(req_ofs), .wr_en(wr_en), .wr_local(wr_local),
    .wr_idx(wr_idx), .wr_base(wr_base), .wr_limit(wr_limit), .wr_gran(wr_gran),
    .out_valid(out_valid), .out_lin(out_lin), .out_fault(out_fault)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {req tag, prot, seg, ofs, exp fault, exp lin}
  localparam int NV = 15;
  localparam logic [85:0] VEC [NV] = '{
    {4'd2, 1'b0, 16'hA1F0, 32'h0000_04C0, 1'b0, 32'h000A_23C0}, // R2 example
    {4'd1, 1'b0, 16'h028F, 32'h0000_0030, 1'b0, 32'h0000_2920}, // R1
    {4'd2, 1'b0, 16'hFFFF, 32'h0000_0010, 1'b0, 32'h0000_0000}, // R2 wrap
    {4'd1, 1'b0, 16'h1234, 32'hFFFF_0005, 1'b0, 32'h0001_2345}, // R1 upper ofs ignored
    {4'd4, 1'b1, 16'h0008, 32'h0000_0000, 1'b0, 32'h0010_0000}, // R4
    {4'd5, 1'b1, 16'h000B, 32'h0000_0FFF, 1'b0, 32'h0010_0FFF}, // R5 at limit, R3 low bits
    {4'd5, 1'b1, 16'h0008, 32'h0000_1000, 1'b1, 32'h0000_0000}, // R5 past limit, R8
    {4'd3, 1'b1, 16'h000C, 32'h0000_0005, 1'b0, 32'h0000_4005}, // R3 local table
    {4'd3, 1'b1, 16'h000C, 32'h0000_0010, 1'b1, 32'h0000_0000}, // R3 local limit
    {4'd6, 1'b1, 16'h0010, 32'h0000_3FFF, 1'b0, 32'h8000_3FFF}, // R6 page at limit
    {4'd6, 1'b1, 16'h0010, 32'h0000_4000, 1'b1, 32'h0000_0000}, // R6 page past
    {4'd4, 1'b1, 16'h0078, 32'h0000_0020, 1'b0, 32'h0000_0010}, // R4 32-bit wrap
    {4'd7, 1'b1, 16'h0080, 32'h0000_0000, 1'b1, 32'h0000_0000}, // R7 index 16
    {4'd10,1'b1, 16'h0000, 32'h0000_0000, 1'b0, 32'h0000_0000}, // R10 entry 0 untouched
    {4'd10,1'b1, 16'h0000, 32'h0000_0001, 1'b1, 32'h0000_0000}  // R10 entry 0 limit 0
  };

  task automatic chk(input int rq, input logic v, input logic f, input logic [31:0] l,
                     input logic ev, input logic ef, input logic [31:0] el);
    checks++;
    if (v !== ev || f !== ef || l !== el) begin
      failures++;
      $display("FAIL R%0d: valid=%0b fault=%0b lin=%h expected valid=%0b fault=%0b lin=%h",
               rq, v, f, l, ev, ef, el);
    end
  endtask

  task automatic wr_desc(input logic loc, input logic [12:0] idx, input logic [31:0] b,
                         input logic [19:0] lim, input logic g);
    wr_en = 1'b1; wr_local = loc; wr_idx = idx; wr_base = b; wr_limit = lim; wr_gran = g;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_prot = 1'b0; req_seg = '0; req_ofs = '0;
    wr_en = 1'b0; wr_local = 1'b0; wr_idx = '0; wr_base = '0; wr_limit = '0; wr_gran = 1'b0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(11, out_valid, out_fault, out_lin, 1'b0, 1'b0, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(11, out_valid, out_fault, out_lin, 1'b0, 1'b0, 32'h0);

    wr_desc(1'b0, 13'd1,  32'h0010_0000, 20'h00FFF, 1'b0);
    wr_desc(1'b0, 13'd2,  32'h8000_0000, 20'h00003, 1'b1);
    wr_desc(1'b1, 13'd1,  32'h0000_4000, 20'h0000F, 1'b0);
    wr_desc(1'b0, 13'd15, 32'hFFFF_FFF0, 20'hFFFFF, 1'b1);
    wr_desc(1'b0, 13'd16, 32'h1234_5678, 20'hFFFFF, 1'b1); // R10 out of range, ignored

    for (int i = 0; i < NV; i++) begin
      req_valid = 1'b1;
      req_prot  = VEC[i][81];
      req_seg   = VEC[i][80:65];
      req_ofs   = VEC[i][64:33];
      @(negedge clk);
      chk(int'(VEC[i][85:82]), out_valid, out_fault, out_lin, 1'b1, VEC[i][32], VEC[i][31:0]);
    end

    // R10: write and request in the same cycle see old contents
    wr_en = 1'b1; wr_local = 1'b0; wr_idx = 13'd3; wr_base = 32'h0000_5000;
    wr_limit = 20'h0000F; wr_gran = 1'b0;
    req_valid = 1'b1; req_prot = 1'b1; req_seg = 16'h0018; req_ofs = 32'h1;
    @(negedge clk);
    chk(10, out_valid, out_fault, out_lin, 1'b1, 1'b1, 32'h0);
    wr_en = 1'b0;
    @(negedge clk);
    chk(10, out_valid, out_fault, out_lin, 1'b1, 1'b0, 32'h0000_5001);

    // R9: idle cycle holds address, drops valid
    req_valid = 1'b0; req_seg = 16'h0008; req_ofs = 32'h7;
    @(negedge clk);
    chk(9, out_valid, out_fault, out_lin, 1'b0, 1'b0, 32'h0000_5001);
    // R9: idle after a fault clears fault
    req_valid = 1'b1; req_prot = 1'b1; req_seg = 16'h0080; req_ofs = 32'h0;
    @(negedge clk);
    chk(7, out_valid, out_fault, out_lin, 1'b1, 1'b1, 32'h0);
    req_valid = 1'b0;
    @(negedge clk);
    chk(9, out_valid, out_fault, out_lin, 1'b0, 1'b0, 32'h0);

    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end
endmodule